// File: doc/BRIEF.md
# Incremental Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a signed-free position count. Every legal edge on either phase moves the count by one step, so one full phase cycle gives four counts. The count lives in the range zero to a programmable limit and wraps at both ends. A direction bit flips the sense of rotation without rewiring the phases.

The once-per-revolution marker input can clear the count, copy it into a holding register, or both, each under its own enable. A separate synchronous strobe, typically issued by the control loop at its sample instant, snapshots the count into a second holding register so that software reads a value taken at a known moment. All settings and results sit behind a small word-addressed register port with registered read data. The count is also driven out directly for hardware consumers.

Top module: `qenc_counter`

## Requirements
- R1: The phase and marker inputs each pass through a two-flop synchronizer; a phase change made between two clock edges shows on `pos_count` after the third rising edge, and not after the second.
- R2: With the direction bit clear, the phase sequence AB = 00, 10, 11, 01, 00 (A leading) raises the count by one per transition, and the reverse order lowers it by one per transition.
- R3: A transition in which A and B change together leaves the count unchanged.
- R4: Control bit 2 set reverses the direction of R2.
- R5: An upward step from a count equal to or above the limit gives zero; the limit resets to 0x3FFF.
- R6: A downward step from zero gives the limit value.
- R7: With control bit 1 set, a rising edge of the synchronized marker clears the count; with it clear the marker leaves the count unchanged.
- R8: With control bit 0 set, a rising edge of the synchronized marker copies the count into the marker-capture register; with it clear that register keeps its value.
- R9: When clear and capture happen on the same marker edge, the captured value is the count before the clear.
- R10: A high `snap_strobe` at a rising edge copies the count held before that edge into the snapshot register.
- R11: A software write of the count takes effect on the next edge and wins over a marker clear and a phase step in the same cycle.
- R12: Register word addresses: 0 control (bits 2:0, other bits read zero), 1 count (read/write), 2 limit (read/write), 3 snapshot (read only), 4 marker capture (read only), others read zero; `bus_rdata` shows the addressed word one edge after the address; all reset to zero except the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder marker pulse, asynchronous |
| snap_strobe | input | 1 | Synchronous snapshot request |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write enable |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| pos_count | output | 32 | Current position count |

## Verification
The phases are driven forward, backward and with forbidden double changes, each from every point of the Gray cycle, so a swapped phase, a wrong sense or a miscounted illegal move shows up as a count mismatch. Wrap is tried upward at the limit and downward at zero, with the limit set both to its reset value and to small random values, which separates an off-by-one wrap from a correct one. Marker pulses are given with every enable combination to tell clear from capture and to show capture precedes clear, and a software write is timed onto the same edge as a phase step to show which wins. The synchronizer depth is measured by sampling the count on the second and third edges after a phase change.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int unsigned ADDR_W = 3;

  // Register word addresses
  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_LIMIT  = 3'd2,
    REG_SNAP   = 3'd3,
    REG_IDXCAP = 3'd4
  } qenc_reg_e;

  // Control word, packed from bit 2 down to bit 0
  typedef struct packed {
    logic reverse;     // bit 2
    logic idx_clr_en;  // bit 1
    logic idx_cap_en;  // bit 0
  } qenc_ctrl_t;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  input  logic z,
  input  logic reverse,
  output logic step_up,
  output logic step_dn,
  output logic idx_rise
);

  logic a_q, b_q, z_q;
  logic fwd, bwd;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
      z_q <= z;
    end
  end

  // A-leading Gray order 00 -> 10 -> 11 -> 01 -> 00
  always_comb begin
    fwd = (a == ~b_q) && (b == a_q);
    bwd = (a == b_q) && (b == ~a_q);
    step_up  = reverse ? bwd : fwd;
    step_dn  = reverse ? fwd : bwd;
    idx_rise = z && !z_q;
  end

  p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step_up, step_dn}));

  p_illegal_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    ((a != a_q) && (b != b_q)) |-> (!step_up && !step_dn));

  p_still_no_step_r2: assert property (@(posedge clk) disable iff (rst)
    ((a == a_q) && (b == b_q)) |-> (!step_up && !step_dn));

endmodule

// File: rtl/qenc_position.sv
module qenc_position #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             idx_rise,
  input  logic             idx_clr_en,
  input  logic             idx_cap_en,
  input  logic             snap,
  input  logic [CNT_W-1:0] limit,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_data,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap_q,
  output logic [CNT_W-1:0] idx_q
);

  logic [CNT_W-1:0] cnt_inc, cnt_dec;
  logic             idx_clr;

  always_comb begin
    cnt_inc = (cnt >= limit) ? '0 : cnt + 1'b1;
    cnt_dec = (cnt == '0) ? limit : cnt - 1'b1;
    idx_clr = idx_rise && idx_clr_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      snap_q <= '0;
      idx_q  <= '0;
    end else begin
      if (snap) snap_q <= cnt;
      if (idx_rise && idx_cap_en) idx_q <= cnt;
      if (sw_wr)        cnt <= sw_data;
      else if (idx_clr) cnt <= '0;
      else if (step_up) cnt <= cnt_inc;
      else if (step_dn) cnt <= cnt_dec;
    end
  end

  p_up_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (step_up && !sw_wr && !idx_clr && (cnt >= limit)) |=> (cnt == '0));

  p_down_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (step_dn && !sw_wr && !idx_clr && (cnt == '0)) |=> (cnt == $past(limit)));

  p_idx_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (idx_clr && !sw_wr) |=> (cnt == '0));

  p_cap_before_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (idx_rise && idx_cap_en) |=> (idx_q == $past(cnt)));

  p_snap_r10: assert property (@(posedge clk) disable iff (rst)
    snap |=> (snap_q == $past(cnt)));

  p_sw_wins_r11: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> (cnt == $past(sw_data)));

  p_cap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(idx_rise && idx_cap_en) |=> $stable(idx_q));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SYNC_STG  = 2,
  parameter logic [CNT_W-1:0] LIMIT_RST = 32'h3FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              snap_strobe,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  pos_count
);
  import qenc_pkg::*;

  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syn_in;
  qenc_ctrl_t       ctrl_q;
  logic [CNT_W-1:0] limit_q, cnt, snap_q, idx_q;
  logic             step_up, step_dn, idx_rise;
  logic             sw_wr;
  qenc_reg_e        reg_sel;

  assign raw_in = {enc_idx, enc_b, enc_a};

  qenc_sync #(.W(NSYNC), .STAGES(SYNC_STG)) i_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_in),
    .dout(syn_in)
  );

  qenc_step_decode i_decode (
    .clk     (clk),
    .rst     (rst),
    .a       (syn_in[0]),
    .b       (syn_in[1]),
    .z       (syn_in[2]),
    .reverse (ctrl_q.reverse),
    .step_up (step_up),
    .step_dn (step_dn),
    .idx_rise(idx_rise)
  );

  assign reg_sel = qenc_reg_e'(bus_addr);
  assign sw_wr   = bus_wr && (reg_sel == REG_COUNT);

  qenc_position #(.CNT_W(CNT_W)) i_position (
    .clk       (clk),
    .rst       (rst),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .idx_rise  (idx_rise),
    .idx_clr_en(ctrl_q.idx_clr_en),
    .idx_cap_en(ctrl_q.idx_cap_en),
    .snap      (snap_strobe),
    .limit     (limit_q),
    .sw_wr     (sw_wr),
    .sw_data   (bus_wdata[CNT_W-1:0]),
    .cnt       (cnt),
    .snap_q    (snap_q),
    .idx_q     (idx_q)
  );

  // Writable settings
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      limit_q <= LIMIT_RST;
    end else if (bus_wr) begin
      if (reg_sel == REG_CTRL)  ctrl_q  <= qenc_ctrl_t'(bus_wdata[2:0]);
      if (reg_sel == REG_LIMIT) limit_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (reg_sel)
        REG_CTRL:   bus_rdata <= DATA_W'(ctrl_q);
        REG_COUNT:  bus_rdata <= DATA_W'(cnt);
        REG_LIMIT:  bus_rdata <= DATA_W'(limit_q);
        REG_SNAP:   bus_rdata <= DATA_W'(snap_q);
        REG_IDXCAP: bus_rdata <= DATA_W'(idx_q);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  assign pos_count = cnt;

  p_ctrl_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == REG_CTRL) |=> (bus_rdata[DATA_W-1:3] == '0));

  p_limit_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (reg_sel == REG_LIMIT)) |=> $stable(limit_q));

endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;

  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, snap_strobe = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pos_count;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model
  int          ph = 0;
  logic [31:0] m_cnt = 0, m_lim = 32'h3FFF, m_snap = 0, m_idx = 0;
  logic [2:0]  m_ctrl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_counter i_qenc_counter (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .snap_strobe(snap_strobe), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pos_count(pos_count)
  );

  function automatic logic [1:0] gray(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [31:0] go_up(input logic [31:0] c, input logic [31:0] l);
    return (c >= l) ? 32'd0 : c + 32'd1;
  endfunction

  function automatic logic [31:0] go_dn(input logic [31:0] c, input logic [31:0] l);
    return (c == 0) ? l : c - 32'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic step(input bit fwd);
    ph = fwd ? (ph + 1) & 3 : (ph + 3) & 3;
    @(negedge clk);
    {enc_a, enc_b} = gray(ph);
    if (fwd ^ m_ctrl[2]) m_cnt = go_up(m_cnt, m_lim);
    else                 m_cnt = go_dn(m_cnt, m_lim);
    settle();
  endtask

  task automatic illegal();
    ph = (ph + 2) & 3;
    @(negedge clk);
    {enc_a, enc_b} = gray(ph);
    settle();
  endtask

  task automatic idx_pulse();
    @(negedge clk);
    enc_idx = 1'b1;
    repeat (3) @(negedge clk);
    enc_idx = 1'b0;
    if (m_ctrl[0]) m_idx = m_cnt;
    if (m_ctrl[1]) m_cnt = 0;
    settle();
  endtask

  task automatic strobe();
    @(negedge clk);
    snap_strobe = 1'b1;
    @(negedge clk);
    snap_strobe = 1'b0;
    m_snap = m_cnt;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      3'd0: m_ctrl = d[2:0];
      3'd1: m_cnt  = d;
      3'd2: m_lim  = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] old;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state (R12, R5)
    check("R12 reset count port", pos_count, 0);
    rd(3'd0, d); check("R12 reset control", d, 0);
    rd(3'd1, d); check("R12 reset count", d, 0);
    rd(3'd2, d); check("R5 reset limit", d, 32'h3FFF);
    rd(3'd3, d); check("R12 reset snapshot", d, 0);
    rd(3'd4, d); check("R12 reset marker capture", d, 0);
    rd(3'd6, d); check("R12 unused address", d, 0);

    // R1 synchronizer latency
    old = pos_count;
    ph = 1;
    @(negedge clk);
    {enc_a, enc_b} = gray(ph);
    m_cnt = go_up(m_cnt, m_lim);
    @(posedge clk); @(posedge clk); #1;
    check("R1 no change after two edges", pos_count, old);
    @(posedge clk); #1;
    check("R1 change after third edge", pos_count, old + 1);
    settle();

    // R2 full cycle forward and back
    for (int i = 0; i < 4; i++) begin step(1); check("R2 forward", pos_count, m_cnt); end
    for (int i = 0; i < 6; i++) begin step(0); check("R2 backward", pos_count, m_cnt); end

    // R3 illegal double change
    old = pos_count;
    illegal();
    check("R3 double change ignored", pos_count, old);

    // R6 downward wrap from zero to reset limit
    wr(3'd1, 0);
    step(0); check("R6 down wrap", pos_count, 32'h3FFF);
    // R5 upward wrap at limit
    step(1); check("R5 up wrap", pos_count, 0);

    // R5/R6 with small limit
    wr(3'd2, 5); wr(3'd1, 5);
    step(1); check("R5 up wrap small limit", pos_count, 0);
    step(0); check("R6 down wrap small limit", pos_count, 5);

    // R4 reverse
    wr(3'd0, 3'b100); wr(3'd1, 2);
    step(1); check("R4 reversed forward", pos_count, 1);
    step(0); check("R4 reversed backward", pos_count, 2);

    // R7 marker clear disabled then enabled
    wr(3'd0, 0); wr(3'd1, 3);
    idx_pulse(); check("R7 clear disabled", pos_count, 3);
    rd(3'd4, d); check("R8 capture disabled keeps value", d, 0);
    wr(3'd0, 3'b010);
    idx_pulse(); check("R7 clear enabled", pos_count, 0);

    // R8 capture only
    wr(3'd0, 3'b001); wr(3'd1, 4);
    idx_pulse();
    check("R8 capture keeps count", pos_count, 4);
    rd(3'd4, d); check("R8 capture value", d, 4);

    // R9 capture and clear together
    wr(3'd0, 3'b011); wr(3'd1, 2);
    idx_pulse();
    check("R9 count cleared", pos_count, 0);
    rd(3'd4, d); check("R9 pre-clear capture", d, 2);

    // R10 snapshot
    wr(3'd0, 0); wr(3'd1, 5);
    strobe();
    step(0);
    rd(3'd3, d); check("R10 snapshot", d, 5);
    check("R10 count moved on", pos_count, 4);

    // R11 write on the same edge as a phase step
    ph = (ph + 1) & 3;
    @(negedge clk);
    {enc_a, enc_b} = gray(ph);
    @(negedge clk);
    @(negedge clk);
    bus_addr = 3'd1; bus_wdata = 32'h3; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_cnt = 3;
    settle();
    check("R11 write wins over step", pos_count, 3);

    // R12 read-only and control width
    wr(3'd3, 32'hABCD);
    rd(3'd3, d); check("R12 snapshot read only", d, 5);
    wr(3'd4, 32'h1234);
    rd(3'd4, d); check("R12 capture read only", d, 2);
    wr(3'd0, 32'hFFFF_FFF8);
    rd(3'd0, d); check("R12 control upper bits", d, 0);
    wr(3'd0, 0);

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom % 10;
      case (r)
        0, 1, 2: step(1);
        3, 4, 5: step(0);
        6: illegal();
        7: idx_pulse();
        8: strobe();
        default: begin
          case ($urandom % 3)
            0: wr(3'd0, 32'($urandom % 8));
            1: wr(3'd2, 32'(2 + $urandom % 11));
            default: wr(3'd1, 32'($urandom % (m_lim + 1)));
          endcase
        end
      endcase
      check("R2 random count", pos_count, m_cnt);
      if (it % 16 == 15) begin
        rd(3'd3, d); check("R10 random snapshot", d, m_snap);
        rd(3'd4, d); check("R8 random capture", d, m_idx);
        rd(3'd2, d); check("R12 random limit", d, m_lim);
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule